// File: doc/BRIEF.md
# ADPCM Sound Effect Player

The block plays short sound effects that are stored one after another as 4-bit ADPCM codes in a 64 KiB sound ROM. It turns each code into one signed 12-bit PCM sample. Samples come out at a fixed rate of 12 kHz, and that rate comes from a divider on the system clock. The ROM sits outside the block. The player drives a byte address and reads the returned byte one clock later.

A request pulse names one of three clips. When a clip starts, the player loads that clip's base address and byte length into its pointer and counter and clears the decoder state. It then streams two codes per byte until the length is used up. Only one clip plays at a time. Requests that arrive during playback are dropped, except for the halt bell. The bell always cuts in and starts from its own beginning. The busy output tells the caller when a new clip can be started.

Top module: `sfx_player`

## Requirements
- R1: `req_clip` selects the clip: 0 is the keypress clip at base address 0, 1 is the bell clip at base 4160, and 2 is the tape read clip at base 24014. A request for one of these while idle is taken on the clock edge where `req_valid` is high. On that edge `busy` rises and `rom_addr` shows the clip's base address.
- R2: The clip lengths are 4160, 19854 and 41448 bytes for keypress, bell and tape read. A clip produces two samples per byte. `busy` stays high until one sample period after the last sample, then falls.
- R3: The first sample appears `TICK_DIV` clocks after the accepting edge, and every further sample follows `TICK_DIV` clocks after the one before. `pcm_out` holds its value between samples.
- R4: The high nibble of each byte is decoded before its low nibble. `rom_addr` moves up by one on the edge that decodes a low nibble. `rom_data` is taken to answer `rom_addr` one clock later.
- R5: The step size is looked up from the standard 49-entry table by a step index. After each code, the index changes by -1 for code magnitudes 0 to 3, and by +2, +4, +6 or +8 for magnitudes 4 to 7. The index is clamped to 0..48.
- R6: Each sample moves the predictor by step/8. Code bit 2 adds step, bit 1 adds step/2 and bit 0 adds step/4, all with truncating division. When bit 3 is set the move is negative.
- R7: The predictor saturates at 2047 and -2048.
- R8: The predictor and the step index are both reset to 0 whenever a clip starts, including a clip that cuts into another.
- R9: While `busy` is high, a request for clip 0 or 2 is ignored. The current clip keeps its address and its sample sequence.
- R10: A bell request is always accepted. It restarts playback at the bell's base address even while a clip, including the bell itself, is playing.
- R11: After reset, and whenever idle, `busy` is 0 and `pcm_out` is 0. A request with code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle play request |
| req_clip | input | 2 | Clip selector for the request |
| rom_addr | output | ADDR_W | Byte address into the sound ROM |
| rom_data | input | 8 | ROM byte, valid one clock after the address |
| busy | output | 1 | High while a clip is playing |
| pcm_out | output | 12 | Signed decoded sample, 0 when idle |

## Verification
The assertions assume a few things about the inputs. The ROM answers every address with exactly one clock of latency. `TICK_DIV` is at least 2, so a fresh byte is ready before the next code is decoded. Each configured clip length is at least one byte. `req_valid` is taken as a pulse that may come at any cycle, including in the middle of a sample period. The bench keeps inside these rules. It models the ROM as one registered lookup computed from the address. It shortens the clip lengths and the divider, but keeps the real base addresses. It drives requests only on falling edges, and some of them land mid-period on purpose. Part of the tape clip holds maximum-magnitude codes of both signs, so saturation and the index ceiling are reached.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam int PCM_W   = 12;
    localparam int IDX_MAX = 48;
    localparam int PCM_MAX = 2047;
    localparam int PCM_MIN = -2048;

    typedef enum logic [1:0] {
        CLIP_KEY  = 2'd0,
        CLIP_BELL = 2'd1,
        CLIP_TAPE = 2'd2,
        CLIP_NONE = 2'd3
    } clip_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PLAY  = 2'd1,
        S_DRAIN = 2'd2
    } play_state_e;

    typedef logic signed [PCM_W-1:0] pcm_t;
    typedef logic [5:0]              idx_t;
    typedef logic [10:0]             step_t;

    typedef struct packed {
        logic       valid;
        logic [3:0] code;
    } nib_t;

    function automatic step_t step_of(idx_t i);
        case (i)
            6'd0:  return 11'd16;   6'd1:  return 11'd17;   6'd2:  return 11'd19;
            6'd3:  return 11'd21;   6'd4:  return 11'd23;   6'd5:  return 11'd25;
            6'd6:  return 11'd28;   6'd7:  return 11'd31;   6'd8:  return 11'd34;
            6'd9:  return 11'd37;   6'd10: return 11'd41;   6'd11: return 11'd45;
            6'd12: return 11'd50;   6'd13: return 11'd55;   6'd14: return 11'd60;
            6'd15: return 11'd66;   6'd16: return 11'd73;   6'd17: return 11'd80;
            6'd18: return 11'd88;   6'd19: return 11'd97;   6'd20: return 11'd107;
            6'd21: return 11'd118;  6'd22: return 11'd130;  6'd23: return 11'd143;
            6'd24: return 11'd157;  6'd25: return 11'd173;  6'd26: return 11'd190;
            6'd27: return 11'd209;  6'd28: return 11'd230;  6'd29: return 11'd253;
            6'd30: return 11'd279;  6'd31: return 11'd307;  6'd32: return 11'd337;
            6'd33: return 11'd371;  6'd34: return 11'd408;  6'd35: return 11'd449;
            6'd36: return 11'd494;  6'd37: return 11'd544;  6'd38: return 11'd598;
            6'd39: return 11'd658;  6'd40: return 11'd724;  6'd41: return 11'd796;
            6'd42: return 11'd876;  6'd43: return 11'd963;  6'd44: return 11'd1060;
            6'd45: return 11'd1166; 6'd46: return 11'd1282; 6'd47: return 11'd1411;
            default: return 11'd1552;
        endcase
    endfunction

    function automatic idx_t next_idx(idx_t i, logic [2:0] mag);
        int n;
        n = int'(i) + (mag[2] ? 2 * (int'(mag[1:0]) + 1) : -1);
        if (n < 0)       n = 0;
        if (n > IDX_MAX) n = IDX_MAX;
        return idx_t'(n);
    endfunction

    function automatic pcm_t next_pred(pcm_t p, step_t step, logic [3:0] c);
        int d;
        int s;
        d = int'(step) >> 3;
        if (c[2]) d = d + int'(step);
        if (c[1]) d = d + (int'(step) >> 1);
        if (c[0]) d = d + (int'(step) >> 2);
        s = int'(p) + (c[3] ? -d : d);
        if (s > PCM_MAX) s = PCM_MAX;
        if (s < PCM_MIN) s = PCM_MIN;
        return pcm_t'(s);
    endfunction

endpackage

// File: rtl/sfx_tick_gen.sv
module sfx_tick_gen #(
    parameter int DIV = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfx_seq.sv
module sfx_seq
    import sfx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int LEN_W     = 17,
    parameter int KEY_BASE  = 0,
    parameter int KEY_LEN   = 4160,
    parameter int BELL_BASE = 4160,
    parameter int BELL_LEN  = 19854,
    parameter int TAPE_BASE = 24014,
    parameter int TAPE_LEN  = 41448
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_clip,
    input  logic              tick,
    input  logic [7:0]        rom_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              busy,
    output logic              accept,
    output logic              dec_clr,
    output nib_t              nib,
    output logic              nib_hi
);
    play_state_e       state;
    logic [ADDR_W-1:0] ptr;
    logic [LEN_W-1:0]  left;
    logic [ADDR_W-1:0] sel_base;
    logic [LEN_W-1:0]  sel_len;

    always_comb begin
        case (clip_e'(req_clip))
            CLIP_BELL: begin sel_base = ADDR_W'(BELL_BASE); sel_len = LEN_W'(BELL_LEN); end
            CLIP_TAPE: begin sel_base = ADDR_W'(TAPE_BASE); sel_len = LEN_W'(TAPE_LEN); end
            default:   begin sel_base = ADDR_W'(KEY_BASE);  sel_len = LEN_W'(KEY_LEN);  end
        endcase
    end

    assign accept = req_valid && (clip_e'(req_clip) != CLIP_NONE) &&
                    ((state == S_IDLE) || (clip_e'(req_clip) == CLIP_BELL));

    assign busy      = (state != S_IDLE);
    assign rom_addr  = ptr;
    assign nib.valid = tick && (state == S_PLAY) && !accept;
    assign nib.code  = nib_hi ? rom_data[7:4] : rom_data[3:0];
    assign dec_clr   = accept || (tick && (state == S_DRAIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            ptr    <= '0;
            left   <= '0;
            nib_hi <= 1'b1;
        end else if (accept) begin
            state  <= S_PLAY;
            ptr    <= sel_base;
            left   <= sel_len;
            nib_hi <= 1'b1;
        end else if (tick) begin
            case (state)
                S_PLAY: begin
                    nib_hi <= !nib_hi;
                    if (!nib_hi) begin
                        ptr  <= ptr + 1'b1;
                        left <= left - 1'b1;
                        if (left == LEN_W'(1)) state <= S_DRAIN;
                    end
                end
                S_DRAIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfx_adpcm_dec.sv
module sfx_adpcm_dec
    import sfx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  nib_t nib,
    output pcm_t pcm,
    output idx_t step_idx
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcm      <= '0;
            step_idx <= '0;
        end else if (nib.valid) begin
            pcm      <= next_pred(pcm, step_of(step_idx), nib.code);
            step_idx <= next_idx(step_idx, nib.code[2:0]);
        end
    end
endmodule

// File: rtl/sfx_player.sv
module sfx_player
    import sfx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int TICK_DIV  = 4000,
    parameter int KEY_BASE  = 0,
    parameter int KEY_LEN   = 4160,
    parameter int BELL_BASE = 4160,
    parameter int BELL_LEN  = 19854,
    parameter int TAPE_BASE = 24014,
    parameter int TAPE_LEN  = 41448
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [1:0]              req_clip,
    output logic [ADDR_W-1:0]       rom_addr,
    input  logic [7:0]              rom_data,
    output logic                    busy,
    output logic signed [PCM_W-1:0] pcm_out
);
    localparam int MAX_KB  = (KEY_LEN > BELL_LEN) ? KEY_LEN : BELL_LEN;
    localparam int MAX_LEN = (MAX_KB > TAPE_LEN) ? MAX_KB : TAPE_LEN;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic tick;
    logic accept;
    logic dec_clr;
    logic nib_hi;
    nib_t nib;
    pcm_t pcm;
    idx_t step_idx;
    logic nib_valid;

    assign nib_valid = nib.valid;
    assign pcm_out   = pcm;

    sfx_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .tick (tick)
    );

    sfx_seq #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .KEY_BASE (KEY_BASE),
        .KEY_LEN  (KEY_LEN),
        .BELL_BASE(BELL_BASE),
        .BELL_LEN (BELL_LEN),
        .TAPE_BASE(TAPE_BASE),
        .TAPE_LEN (TAPE_LEN)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_clip (req_clip),
        .tick     (tick),
        .rom_data (rom_data),
        .rom_addr (rom_addr),
        .busy     (busy),
        .accept   (accept),
        .dec_clr  (dec_clr),
        .nib      (nib),
        .nib_hi   (nib_hi)
    );

    sfx_adpcm_dec u_dec (
        .clk      (clk),
        .rst      (rst),
        .clr      (dec_clr),
        .nib      (nib),
        .pcm      (pcm),
        .step_idx (step_idx)
    );
endmodule

// File: rtl/sfx_player_chk.sv
module sfx_player_chk #(
    parameter int ADDR_W    = 16,
    parameter int BELL_BASE = 4160
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_clip,
    input logic              busy,
    input logic [11:0]       pcm_out,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              accept,
    input logic              nib_valid,
    input logic              nib_hi,
    input logic              dec_clr,
    input logic [5:0]        step_idx
);
    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_clip != 2'd3) |=> busy);

    p_pcm_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(pcm_out) |-> $past(nib_valid || dec_clr));

    p_addr_moves_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rom_addr) |-> ($past(accept) || $past(nib_valid && !nib_hi)));

    p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
        step_idx <= 6'd48);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && req_clip != 2'd1 && !nib_valid) |=> $stable(rom_addr));

    p_bell_preempt_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_clip == 2'd1) |=> (busy && rom_addr == ADDR_W'(BELL_BASE)));

    p_idle_silent_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pcm_out == 12'd0));

    p_invalid_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_clip == 2'd3) |=> !busy);
endmodule

bind sfx_player sfx_player_chk #(
    .ADDR_W   (ADDR_W),
    .BELL_BASE(BELL_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_clip (req_clip),
    .busy     (busy),
    .pcm_out  (pcm_out),
    .rom_addr (rom_addr),
    .accept   (accept),
    .nib_valid(nib_valid),
    .nib_hi   (nib_hi),
    .dec_clr  (dec_clr),
    .step_idx (step_idx)
);

// File: tb/sfx_player_tb.sv
`timescale 1ns/1ps
module sfx_player_tb_top;

    localparam int D         = 4;
    localparam int KEY_LEN   = 3;
    localparam int BELL_LEN  = 5;
    localparam int TAPE_LEN  = 12;
    localparam int KEY_BASE  = 0;
    localparam int BELL_BASE = 4160;
    localparam int TAPE_BASE = 24014;

    localparam int STEP_TAB [49] = '{16,17,19,21,23,25,28,31,34,37,41,45,50,55,60,66,
        73,80,88,97,107,118,130,143,157,173,190,209,230,253,279,307,337,371,408,449,
        494,544,598,658,724,796,876,963,1060,1166,1282,1411,1552};
    localparam int ADJ [8] = '{-1,-1,-1,-1,2,4,6,8};

    // stimulus vectors: {clip code, expected base address}
    localparam int VEC [4][2] = '{'{0, 0}, '{1, 4160}, '{2, 24014}, '{0, 0}};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_clip = 2'd0;
    logic [15:0]       rom_addr;
    logic [7:0]        rom_q = 8'd0;
    logic              busy;
    logic signed [11:0] pcm;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int m_pred, m_idx, m_addr, m_left;
    bit m_hi;

    always #2.5 clk = ~clk;

    sfx_player #(
        .ADDR_W(16), .TICK_DIV(D),
        .KEY_BASE(KEY_BASE), .KEY_LEN(KEY_LEN),
        .BELL_BASE(BELL_BASE), .BELL_LEN(BELL_LEN),
        .TAPE_BASE(TAPE_BASE), .TAPE_LEN(TAPE_LEN)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_clip(req_clip),
        .rom_addr(rom_addr), .rom_data(rom_q), .busy(busy), .pcm_out(pcm)
    );

    function automatic logic [7:0] rom_byte(int a);
        if (a >= TAPE_BASE && a < TAPE_BASE + 6)       return 8'h77;
        if (a >= TAPE_BASE + 6 && a < TAPE_BASE + 12)  return 8'hFF;
        if (a == 0)                                    return 8'h21;
        return 8'((a * 37) ^ (a >> 2) ^ 8'h5A);
    endfunction

    always @(posedge clk) rom_q <= rom_byte(int'(rom_addr));

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int base_of(int c);
        return (c == 1) ? BELL_BASE : (c == 2) ? TAPE_BASE : KEY_BASE;
    endfunction
    function automatic int len_of(int c);
        return (c == 1) ? BELL_LEN : (c == 2) ? TAPE_LEN : KEY_LEN;
    endfunction

    task automatic begin_clip(int c);
        m_pred = 0; m_idx = 0; m_addr = base_of(c); m_left = len_of(c); m_hi = 1'b1;
    endtask

    // entered at a falling edge; returns at the falling edge after the request edge
    task automatic pulse_req(int c);
        req_valid = 1'b1;
        req_clip  = 2'(c);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic model_step();
        logic [7:0] b;
        int code, st, d;
        b    = rom_byte(m_addr);
        code = m_hi ? int'(b[7:4]) : int'(b[3:0]);
        st   = STEP_TAB[m_idx];
        d    = st / 8;
        if (code & 4) d += st;
        if (code & 2) d += st / 2;
        if (code & 1) d += st / 4;
        m_pred = (code & 8) ? m_pred - d : m_pred + d;
        if (m_pred > 2047)  m_pred = 2047;
        if (m_pred < -2048) m_pred = -2048;
        m_idx += ADJ[code & 7];
        if (m_idx < 0)  m_idx = 0;
        if (m_idx > 48) m_idx = 48;
        if (!m_hi) begin m_addr++; m_left--; end
        m_hi = !m_hi;
    endtask

    task automatic next_sample(int waits, string tag);
        repeat (waits - 1) @(negedge clk);
        check("R3 hold", int'(pcm), m_pred);
        @(negedge clk);
        model_step();
        check(tag, int'(pcm), m_pred);
        check("R2 busy", int'(busy), 1);
        check("R4 addr", int'(rom_addr), m_addr);
    endtask

    task automatic play_rest(string tag);
        while (m_left > 0) next_sample(D, tag);
        repeat (D - 1) @(negedge clk);
        check("R2 busy before end", int'(busy), 1);
        @(negedge clk);
        check("R2 busy end", int'(busy), 0);
        check("R11 pcm idle", int'(pcm), 0);
    endtask

    task automatic start_clip(int c);
        pulse_req(c);
        begin_clip(c);
        check("R1 busy", int'(busy), 1);
        check("R1 base", int'(rom_addr), base_of(c));
        check("R8 cleared", int'(pcm), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R11 reset busy", int'(busy), 0);
        check("R11 reset pcm", int'(pcm), 0);
        rst = 1'b0;
        @(negedge clk);

        // code 3 ignored while idle
        pulse_req(3);
        check("R11 code3", int'(busy), 0);
        repeat (D + 1) @(negedge clk);
        check("R11 code3 later", int'(busy), 0);
        check("R11 code3 pcm", int'(pcm), 0);

        // vector walk: full clips
        for (int i = 0; i < 4; i++) begin
            start_clip(VEC[i][0]);
            check("R1 table base", int'(rom_addr), VEC[i][1]);
            play_rest(VEC[i][0] == 0 ? "R5 key" : VEC[i][0] == 1 ? "R6 bell" : "R7 tape");
            @(negedge clk);
        end

        // R9: keypress and tape requests ignored while busy
        start_clip(2);
        for (int k = 0; k < 3; k++) next_sample(D, "R7 tape");
        pulse_req(0);
        check("R9 addr kept", int'(rom_addr), m_addr);
        next_sample(D - 1, "R9 sample");
        pulse_req(2);
        check("R9 addr kept tape", int'(rom_addr), m_addr);
        next_sample(D - 1, "R9 sample tape");
        play_rest("R9 rest");
        @(negedge clk);

        // R10: bell preempts the tape clip mid-period
        start_clip(2);
        for (int k = 0; k < 5; k++) next_sample(D, "R7 tape");
        @(negedge clk);
        start_clip(1);
        check("R10 bell base", int'(rom_addr), BELL_BASE);
        next_sample(D, "R8 first after preempt");
        play_rest("R10 bell");
        @(negedge clk);

        // R10: bell restarts itself
        start_clip(1);
        for (int k = 0; k < 3; k++) next_sample(D, "R6 bell");
        start_clip(1);
        check("R10 restart base", int'(rom_addr), BELL_BASE);
        play_rest("R10 restart");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R2 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule